// File: doc/BRIEF.md
# EOI-Gated Interrupt Aggregator

This block gathers transmit-endpoint, receive-endpoint, core-event and VBUS-drive-change event lines into one 32-bit pending vector. Each hardware event line is captured on its rising edge. Software sees the pending vector and an enable mask through a small word-addressed register bus. It can force or acknowledge pending bits with write-one-to-set and write-one-to-clear ports, and it can change the mask through its own pair of such ports. A read-only view returns the pending bits that are enabled.

A single interrupt line goes high when an enabled bit is pending and the block is armed. Raising the line disarms the block. The line falls again once nothing enabled is pending, but it cannot rise a second time until software writes any value to the end-of-interrupt address. A typical service routine reads the enabled view, writes that value back to the clear port, and then writes the end-of-interrupt address. A soft-reset bit in the control word returns the pending vector, the mask and the gating state to their reset values.

Top module: `irq_eoi_aggregator`

## Requirements
- R1: After reset, the pending vector and the mask read 0, irqOut is 0, and address 0x00 reads the nonzero REV_ID parameter (default 0x0A610203).
- R2: Pending bit positions are fixed. txEvt[4:0] maps to bits 4:0, rxEvt[3:0] to bits 12:9, coreEvt[7:0] to bits 23:16, and vbusEvt to bit 24. Every other bit of the pending vector and of the mask always reads 0.
- R3: A 0-to-1 transition on an event input sets its pending bit at the clock edge where the input is first sampled high. An input that stays high does not set the bit again after the bit has been cleared.
- R4: Writing to 0x24 sets every pending bit whose write-data bit is 1. Writing to 0x28 clears every pending bit whose write-data bit is 1. Write-data bits that are 0 leave their pending bits unchanged.
- R5: Writing to 0x30 sets mask bits and writing to 0x34 clears mask bits, both for write-data bits that are 1. The mask reads at 0x2C, 0x30 and 0x34. The pending vector reads at 0x20, 0x24 and 0x28. Writes to 0x20 and 0x2C have no effect.
- R6: Address 0x38 reads the pending vector ANDed with the mask. Writing that value to 0x28 clears exactly those bits.
- R7: irqOut rises one cycle after the enabled pending set becomes nonzero while the block is armed, and falls one cycle after that set becomes empty. Once irqOut has risen, it stays low on new events until any write to 0x3C re-arms the block. Reset leaves the block armed.
- R8: If an event edge and a write to 0x28 target the same bit in the same cycle, the bit ends up set.
- R9: A write to 0x04 with bit 0 set clears the pending vector, clears the mask, drops irqOut and re-arms the block. A write to 0x04 with bit 0 clear has no effect. Reads of 0x04, 0x3C and any unused address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWe | input | 1 | Write strobe for the current address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| txEvt | input | 5 | Transmit-endpoint event lines |
| rxEvt | input | 4 | Receive-endpoint event lines |
| coreEvt | input | 8 | Core event lines |
| vbusEvt | input | 1 | VBUS-drive change event line |
| irqOut | output | 1 | Gated level interrupt |

## Verification
The bench targets these corner cases:
- An event edge that coincides with a clear write. A design that gives the clear priority would lose that event.
- An event input held high across an acknowledge. A level-sensitive capture would re-pend the bit at once.
- A second event arriving after the line has fallen but before the end-of-interrupt write. A design without the arm flag would pulse the line again, and a design that never re-arms would stay silent after the end-of-interrupt write.
- All-ones writes to the set and mask-set ports, and writes to the read-only aliases. These expose reserved bits that leak into the vector and aliases that accept writes.
- A soft-reset write with bit 0 clear. A decoder that ignores the data bit would clear the block here.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W   = 32;
  localparam int TX_N     = 5;
  localparam int TX_LSB   = 0;
  localparam int RX_N     = 4;
  localparam int RX_LSB   = 9;
  localparam int CORE_N   = 8;
  localparam int CORE_LSB = 16;
  localparam int VBUS_BIT = 24;

  localparam int OFF_REV     = 'h00;
  localparam int OFF_CTL     = 'h04;
  localparam int OFF_SRC     = 'h20;
  localparam int OFF_SRC_SET = 'h24;
  localparam int OFF_SRC_CLR = 'h28;
  localparam int OFF_MSK     = 'h2C;
  localparam int OFF_MSK_SET = 'h30;
  localparam int OFF_MSK_CLR = 'h34;
  localparam int OFF_MASKED  = 'h38;
  localparam int OFF_EOI     = 'h3C;

  // One-cycle strobes from the decoder to the state holding logic.
  typedef struct packed {
    logic srcSet;
    logic srcClr;
    logic mskSet;
    logic mskClr;
    logic eoi;
    logic softRst;
  } strobe_t;

  function automatic logic [DATA_W-1:0] validBits();
    logic [DATA_W-1:0] v;
    v = '0;
    v[TX_LSB +: TX_N]     = '1;
    v[RX_LSB +: RX_N]     = '1;
    v[CORE_LSB +: CORE_N] = '1;
    v[VBUS_BIT]           = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [DATA_W-1:0] REV_ID = 32'h0A61_0203
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              ctlBit0,
  input  logic [DATA_W-1:0] srcQ,
  input  logic [DATA_W-1:0] mskQ,
  output strobe_t           strb,
  output logic [DATA_W-1:0] regRdata
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  // Write decode: at most one strobe per cycle.
  always_comb begin
    strb = '0;
    if (regWe) begin
      strb.srcSet  = hit(regAddr, OFF_SRC_SET);
      strb.srcClr  = hit(regAddr, OFF_SRC_CLR);
      strb.mskSet  = hit(regAddr, OFF_MSK_SET);
      strb.mskClr  = hit(regAddr, OFF_MSK_CLR);
      strb.eoi     = hit(regAddr, OFF_EOI);
      strb.softRst = hit(regAddr, OFF_CTL) && ctlBit0;
    end
  end

  // Read mux; source aliases and mask aliases share their views.
  always_comb begin
    regRdata = '0;
    if (hit(regAddr, OFF_REV))
      regRdata = REV_ID;
    else if (hit(regAddr, OFF_SRC) || hit(regAddr, OFF_SRC_SET) || hit(regAddr, OFF_SRC_CLR))
      regRdata = srcQ;
    else if (hit(regAddr, OFF_MSK) || hit(regAddr, OFF_MSK_SET) || hit(regAddr, OFF_MSK_CLR))
      regRdata = mskQ;
    else if (hit(regAddr, OFF_MASKED))
      regRdata = srcQ & mskQ;
  end

  // R4 R5 R7 R9: decoded strobes never overlap
  a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TX_N-1:0]   txEvt,
  input  logic [RX_N-1:0]   rxEvt,
  input  logic [CORE_N-1:0] coreEvt,
  input  logic              vbusEvt,
  output logic [DATA_W-1:0] srcQ,
  output logic [DATA_W-1:0] mskQ,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] VALID = validBits();

  logic [DATA_W-1:0] hwLevel, prevQ, hwEdge;
  logic [DATA_W-1:0] srcNext, mskNext, swSet, swClr, mSet, mClr;
  logic              irqQ, armedQ, anyPend, irqNext, armedNext;

  // Place each event group at its bit field.
  always_comb begin
    hwLevel = '0;
    hwLevel[TX_LSB +: TX_N]     = txEvt;
    hwLevel[RX_LSB +: RX_N]     = rxEvt;
    hwLevel[CORE_LSB +: CORE_N] = coreEvt;
    hwLevel[VBUS_BIT]           = vbusEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= hwLevel;
  end

  assign hwEdge = hwLevel & ~prevQ;

  assign swSet = strb.srcSet ? wdata : '0;
  assign swClr = strb.srcClr ? wdata : '0;
  assign mSet  = strb.mskSet ? wdata : '0;
  assign mClr  = strb.mskClr ? wdata : '0;

  // Hardware edges are ORed in after the clear, so they win.
  assign srcNext = (((srcQ | swSet) & ~swClr) | hwEdge) & VALID;
  assign mskNext = ((mskQ | mSet) & ~mClr) & VALID;

  assign anyPend   = |(srcQ & mskQ);
  assign irqNext   = anyPend && (irqQ || armedQ);
  assign armedNext = strb.eoi || (armedQ && !anyPend);

  always_ff @(posedge clk) begin
    if (!rstN || strb.softRst) begin
      srcQ   <= '0;
      mskQ   <= '0;
      irqQ   <= 1'b0;
      armedQ <= 1'b1;
    end else begin
      srcQ   <= srcNext;
      mskQ   <= mskNext;
      irqQ   <= irqNext;
      armedQ <= armedNext;
    end
  end

  assign irqOut = irqQ;

  logic [DATA_W-1:0] hwKeep;
  assign hwKeep = hwEdge & {DATA_W{!strb.softRst}};

  // R7: the line only rises from the armed state
  a_r7_rise_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(armedQ));
  // R7: disarming happens only together with raising the line
  a_r7_disarm_with_irq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(armedQ) |-> irqOut);
  // R7: an end-of-interrupt write always leaves the block armed
  a_r7_eoi_rearms: assert property (@(posedge clk) disable iff (!rstN)
    strb.eoi && !strb.softRst |=> armedQ);
  // R8: a captured edge is pending next cycle whatever software wrote
  a_r8_hw_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((srcQ & $past(hwKeep)) == $past(hwKeep)));
  // R9: soft reset empties the pending vector and the mask
  a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (srcQ == '0 && mskQ == '0 && !irqOut));
endmodule

// File: rtl/irq_eoi_aggregator.sv
module irq_eoi_aggregator
  import irq_agg_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [DATA_W-1:0] REV_ID = 32'h0A61_0203
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [TX_N-1:0]   txEvt,
  input  logic [RX_N-1:0]   rxEvt,
  input  logic [CORE_N-1:0] coreEvt,
  input  logic              vbusEvt,
  output logic              irqOut
);
  strobe_t           strb;
  logic [DATA_W-1:0] srcQ, mskQ;

  irq_agg_ctrl #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .ctlBit0  (regWdata[0]),
    .srcQ     (srcQ),
    .mskQ     (mskQ),
    .strb     (strb),
    .regRdata (regRdata)
  );

  irq_agg_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (regWdata),
    .txEvt   (txEvt),
    .rxEvt   (rxEvt),
    .coreEvt (coreEvt),
    .vbusEvt (vbusEvt),
    .srcQ    (srcQ),
    .mskQ    (mskQ),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/test_irq_eoi_aggregator.sv
module test_irq_eoi_aggregator;
  localparam logic [31:0] REV = 32'h0A61_0203;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [4:0]  txEvt = '0;
  logic [3:0]  rxEvt = '0;
  logic [7:0]  coreEvt = '0;
  logic        vbusEvt = 1'b0;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  irq_eoi_aggregator #(.ADDR_W(8), .REV_ID(REV)) i_irq_eoi_aggregator (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .txEvt(txEvt), .rxEvt(rxEvt),
    .coreEvt(coreEvt), .vbusEvt(vbusEvt), .irqOut(irqOut)
  );

  // Reference model, written from the requirements.
  logic [31:0] mSrc = '0, mMsk = '0, mPrev = '0;
  logic        mIrq = 1'b0, mArm = 1'b1;
  localparam logic [31:0] LEGAL = 32'h01FF_1E1F;

  always @(posedge clk) begin
    logic [31:0] lvl, edges;
    logic        pend;
    lvl = {7'b0, vbusEvt, coreEvt, 3'b0, rxEvt, 4'b0, txEvt};
    if (!rstN) begin
      mSrc = '0; mMsk = '0; mPrev = '0; mIrq = 1'b0; mArm = 1'b1;
    end else begin
      edges = lvl & ~mPrev;
      mPrev = lvl;
      pend  = (mSrc & mMsk) != 0;
      mIrq  = pend && (mIrq || mArm);
      mArm  = (regWe && regAddr == 8'h3C) || (mArm && !pend);
      if (regWe && regAddr == 8'h24) mSrc = mSrc | regWdata;
      if (regWe && regAddr == 8'h28) mSrc = mSrc & ~regWdata;
      if (regWe && regAddr == 8'h30) mMsk = mMsk | regWdata;
      if (regWe && regAddr == 8'h34) mMsk = mMsk & ~regWdata;
      mSrc = (mSrc | edges) & LEGAL;
      mMsk = mMsk & LEGAL;
      if (regWe && regAddr == 8'h04 && regWdata[0]) begin
        mSrc = '0; mMsk = '0; mIrq = 1'b0; mArm = 1'b1;
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00:               return REV;
      8'h20, 8'h24, 8'h28: return mSrc;
      8'h2C, 8'h30, 8'h34: return mMsk;
      8'h38:               return mSrc & mMsk;
      default:             return 32'h0;
    endcase
  endfunction

  task automatic expectEq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    expectEq(curReq, "read data vs model", regRdata, expRead(regAddr));
    expectEq(curReq, "irqOut vs model", {31'b0, irqOut}, {31'b0, mIrq});
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWe = 1'b1; regWdata = d;
    cyc();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic busRd(input logic [7:0] a);
    regAddr = a; regWe = 1'b0;
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] mk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    curReq = "R1";
    busRd(8'h20); expectEq("R1", "pending after reset", regRdata, 0);
    busRd(8'h2C); expectEq("R1", "mask after reset", regRdata, 0);
    busRd(8'h00); expectEq("R1", "revision", regRdata, REV);
    expectEq("R1", "irq after reset", {31'b0, irqOut}, 0);

    // R2 R3 bit placement via event edges
    curReq = "R2";
    regAddr = 8'h20;
    txEvt = 5'b10101; cyc(); txEvt = '0; cyc();
    expectEq("R2", "tx field", regRdata, 32'h0000_0015);
    rxEvt = 4'hF; cyc(); rxEvt = '0; cyc();
    expectEq("R2", "rx field", regRdata, 32'h0000_1E15);
    coreEvt = 8'hA5; vbusEvt = 1'b1; cyc(); coreEvt = '0; vbusEvt = 1'b0; cyc();
    expectEq("R3", "core and vbus edges", regRdata, 32'h01A5_1E15);
    busWr(8'h24, 32'hFFFF_FFFF);
    expectEq("R2", "reserved bits stay zero", regRdata, LEGAL);

    // R4 software clear and set
    curReq = "R4";
    busWr(8'h28, 32'hFFFF_FFFF);
    expectEq("R4", "clear all", regRdata, 0);
    busWr(8'h24, 32'h0001_0003);
    busWr(8'h24, 32'h0000_0000);
    expectEq("R4", "zero set write", regRdata, 32'h0001_0003);
    busWr(8'h28, 32'h0000_0001);
    expectEq("R4", "partial clear", regRdata, 32'h0001_0002);

    // R3 held level does not re-pend
    curReq = "R3";
    regAddr = 8'h20;
    txEvt[3] = 1'b1; cyc(); idle(2);
    busWr(8'h28, 32'h0000_0008);
    idle(3);
    expectEq("R3", "held input after clear", regRdata, 32'h0001_0002);
    txEvt[3] = 1'b0; cyc();

    // R5 mask ports and read-only aliases
    curReq = "R5";
    busWr(8'h30, 32'hFFFF_FF0F);
    expectEq("R5", "mask set", regRdata, 32'h01FF_1E0F);
    busWr(8'h34, 32'h00F0_000F);
    busRd(8'h2C); expectEq("R5", "mask clear", regRdata, 32'h010F_1E00);
    busWr(8'h20, 32'h0000_0000);
    busWr(8'h2C, 32'hFFFF_FFFF);
    busRd(8'h2C); expectEq("R5", "mask write ignored", regRdata, 32'h010F_1E00);
    busRd(8'h28); expectEq("R5", "source write ignored", regRdata, 32'h0001_0002);

    // R6 masked view and acknowledge
    curReq = "R6";
    busWr(8'h24, 32'h0100_0600);
    busRd(8'h38); mk = regRdata;
    expectEq("R6", "masked view", mk, 32'h0101_0600);
    busWr(8'h28, mk);
    busRd(8'h20); expectEq("R6", "ack exact bits", regRdata, 32'h0000_0002);

    // R7 gating: this flow starts from a fresh block
    curReq = "R7";
    busWr(8'h04, 32'h1);
    busWr(8'h30, 32'hFFFF_FFFF);
    regAddr = 8'h38;
    vbusEvt = 1'b1; cyc(); vbusEvt = 1'b0;
    idle(2);
    expectEq("R7", "irq raised", {31'b0, irqOut}, 1);
    busWr(8'h28, 32'h0100_0000);
    idle(2);
    expectEq("R7", "irq dropped", {31'b0, irqOut}, 0);
    coreEvt[2] = 1'b1; cyc(); coreEvt[2] = 1'b0;
    idle(4);
    expectEq("R7", "no re-raise without EOI", {31'b0, irqOut}, 0);
    busWr(8'h3C, 32'h0);
    idle(2);
    expectEq("R7", "raise after EOI", {31'b0, irqOut}, 1);
    busWr(8'h28, 32'h0004_0000);
    busWr(8'h3C, 32'h1234);
    idle(2);
    txEvt[0] = 1'b1; cyc(); txEvt[0] = 1'b0;
    idle(2);
    expectEq("R7", "early EOI lets next through", {31'b0, irqOut}, 1);

    // R8 edge versus clear collision
    curReq = "R8";
    busWr(8'h28, 32'hFFFF_FFFF);
    txEvt[1] = 1'b1;
    busWr(8'h28, 32'h0000_0002);
    txEvt[1] = 1'b0;
    busRd(8'h20); expectEq("R8", "hardware set wins", regRdata, 32'h0000_0002);

    // R9 control word
    curReq = "R9";
    busWr(8'h04, 32'h0000_0000);
    busRd(8'h20); expectEq("R9", "ctl bit0 clear no effect", regRdata, 32'h0000_0002);
    busRd(8'h04); expectEq("R9", "ctl reads zero", regRdata, 0);
    busRd(8'h3C); expectEq("R9", "eoi reads zero", regRdata, 0);
    busRd(8'h44); expectEq("R9", "unused reads zero", regRdata, 0);
    busWr(8'h04, 32'h0000_0001);
    busRd(8'h20); expectEq("R9", "soft reset source", regRdata, 0);
    busRd(8'h30); expectEq("R9", "soft reset mask", regRdata, 0);
    expectEq("R9", "soft reset irq", {31'b0, irqOut}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule